// File: doc/BRIEF.md
# Decrement-and-Branch Loop Step Unit

This block performs one step of a hardware loop. On each request it evaluates a 4-bit condition code against the processor flags. When the condition holds, the loop is finished and execution falls through past the displacement word. When it does not hold, the low half of a selected 32-bit counter register is decremented by one. The block then either leaves the loop because the 16-bit count wrapped to all ones, or branches back by a signed 16-bit displacement.

The eight counter registers live inside the block. A load port lets the surrounding datapath place a value in any counter. Each request produces a one-cycle completion pulse with registered results: the counter value after the step, a write indication, the next program counter and the cycle cost of the path taken. A condition that never holds turns the unit into a pure counted loop.

Top module: `dbloop_unit`

## Requirements
- R1: If the selected condition holds, the step reports next PC = PC + 2, cost 12, write indication low, and the counter register is left unchanged.
- R2: If the condition does not hold, the low 16 bits of the selected counter decrease by one (modulo 2^16), the upper 16 bits are kept, the write indication is high, and the new value is stored in the register.
- R3: If the decremented low half equals 0xFFFF, the step reports next PC = PC + 2 and cost 14.
- R4: Otherwise the step reports next PC = PC + sign-extended displacement, where PC is the address of the displacement word, and cost 10.
- R5: The flags input is {N, Z, V, C} in bits 3..0. Condition codes: 0 always, 1 never, 2 !C&!Z, 3 C|Z, 4 !C, 5 C, 6 !Z, 7 Z, 8 !V, 9 V, 10 !N, 11 N, 12 N==V, 13 N!=V, 14 N==V & !Z, 15 Z | N!=V.
- R6: Condition code 1 never holds, so every step with it decrements the counter whatever the flags.
- R7: Synchronous active-high reset clears all eight counters and every output to zero.
- R8: The completion pulse is high exactly in the cycle after each accepted step request, and the result outputs hold their values between steps.
- R9: A load writes the given value into the indexed counter at the next edge. If a step writes the same counter in the same cycle, the step's value is kept; a load to a different counter, or during a step whose condition holds, takes effect.
- R10: The condition code is opcode bits 11:8 and the counter index is opcode bits 2:0; all other opcode bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Step request, sampled on the rising edge |
| opcode_i | input | 16 | Instruction word with condition and counter index |
| ccr_i | input | 4 | Flags {N, Z, V, C} |
| pc_i | input | 32 | Address of the displacement word |
| disp_i | input | 16 | Signed displacement word |
| ld_en_i | input | 1 | Counter load strobe |
| ld_idx_i | input | 3 | Counter index for the load |
| ld_val_i | input | 32 | Value to load |
| done_o | output | 1 | One-cycle completion pulse |
| cnt_o | output | 32 | Counter value after the step |
| cnt_we_o | output | 1 | High when the step wrote the counter |
| next_pc_o | output | 32 | Next program counter |
| cycles_o | output | 5 | Cycle cost of the path taken |

## Verification
The bench builds the unit with its default parameters: a 32-bit counter with a 16-bit count field, 32-bit addresses, a 16-bit displacement and eight counters. With a 16-bit count field, small preloaded values reach the wrap to 0xFFFF in a few steps, so all three exits can be walked in sequence while the upper half carries a marker pattern. The 16 condition codes are each swept against all 16 flag combinations, and back-to-back steps on one counter exercise the read-after-writeback path.

// File: rtl/dbloop_pkg.sv
package dbloop_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  typedef enum logic [1:0] {
    PATH_HIT  = 2'd0,
    PATH_WRAP = 2'd1,
    PATH_LOOP = 2'd2
  } path_e;

  localparam int unsigned COST_HIT  = 12;
  localparam int unsigned COST_WRAP = 14;
  localparam int unsigned COST_LOOP = 10;
  localparam int unsigned COND_W    = 4;

endpackage

// File: rtl/dbloop_cond.sv
module dbloop_cond
  import dbloop_pkg::*;
(
  input  logic [COND_W-1:0] code_i,
  input  ccr_t              ccr_i,
  output logic              hit_o
);

  logic sign_match;
  assign sign_match = (ccr_i.n == ccr_i.v);

  always_comb begin
    unique case (code_i)
      4'd0:    hit_o = 1'b1;
      4'd1:    hit_o = 1'b0;
      4'd2:    hit_o = !ccr_i.c && !ccr_i.z;
      4'd3:    hit_o = ccr_i.c || ccr_i.z;
      4'd4:    hit_o = !ccr_i.c;
      4'd5:    hit_o = ccr_i.c;
      4'd6:    hit_o = !ccr_i.z;
      4'd7:    hit_o = ccr_i.z;
      4'd8:    hit_o = !ccr_i.v;
      4'd9:    hit_o = ccr_i.v;
      4'd10:   hit_o = !ccr_i.n;
      4'd11:   hit_o = ccr_i.n;
      4'd12:   hit_o = sign_match;
      4'd13:   hit_o = !sign_match;
      4'd14:   hit_o = sign_match && !ccr_i.z;
      default: hit_o = ccr_i.z || !sign_match;
    endcase
  end

endmodule

// File: rtl/dbloop_step.sv
module dbloop_step
  import dbloop_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic              hit_i,
  input  logic [DATA_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [DATA_W-1:0] new_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output path_e             path_o
);

  localparam int unsigned HI_W  = DATA_W - CNT_W;
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [CNT_W-1:0]  cnt_dec;
  logic [HI_W-1:0]   hi_keep;
  logic              wrapped;
  logic [ADDR_W-1:0] fall_pc;
  logic [ADDR_W-1:0] back_pc;

  assign hi_keep = cur_i[DATA_W-1:CNT_W];
  assign cnt_dec = cur_i[CNT_W-1:0] - CNT_W'(1);
  assign wrapped = &cnt_dec;
  assign fall_pc = pc_i + ADDR_W'(2);
  assign back_pc = pc_i + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

  always_comb begin
    if (hit_i) begin
      new_o     = cur_i;
      we_o      = 1'b0;
      next_pc_o = fall_pc;
      path_o    = PATH_HIT;
    end else begin
      new_o = {hi_keep, cnt_dec};
      we_o  = 1'b1;
      if (wrapped) begin
        next_pc_o = fall_pc;
        path_o    = PATH_WRAP;
      end else begin
        next_pc_o = back_pc;
        path_o    = PATH_LOOP;
      end
    end
  end

endmodule

// File: rtl/dbloop_regfile.sv
module dbloop_regfile #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_val_o,
  input  logic              sw_en_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic [DATA_W-1:0] sw_val_i,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_val_i
);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[g] <= '0;
      end else if (sw_en_i && sw_idx_i == IDX_W'(g)) begin
        mem[g] <= sw_val_i;
      end else if (ld_en_i && ld_idx_i == IDX_W'(g)) begin
        mem[g] <= ld_val_i;
      end
    end
  end

  assign rd_val_o = mem[rd_idx_i];

  // R9: step writeback dominates a same-cycle load to the same counter
  a_r9_step_wins: assert property (@(posedge clk) disable iff (rst)
    (sw_en_i && ld_en_i && sw_idx_i == ld_idx_i) |=> mem[$past(sw_idx_i)] == $past(sw_val_i));

  // R9: a load with no competing step lands
  a_r9_load_lands: assert property (@(posedge clk) disable iff (rst)
    (ld_en_i && !(sw_en_i && sw_idx_i == ld_idx_i)) |=> mem[$past(ld_idx_i)] == $past(ld_val_i));

endmodule

// File: rtl/dbloop_unit.sv
module dbloop_unit
  import dbloop_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned NREG   = 8,
  parameter int unsigned OP_W   = 16,
  parameter int unsigned CYC_W  = 5,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [3:0]        ccr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_val_i,
  output logic              done_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              cnt_we_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic [CYC_W-1:0]  cycles_o
);

  localparam int unsigned COND_LSB = 8;

  logic [COND_W-1:0] cond_code;
  logic [IDX_W-1:0]  cnt_idx;
  logic              unused_op_bits;
  logic              cond_hit;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] new_val;
  logic              new_we;
  logic [ADDR_W-1:0] new_pc;
  path_e             path;
  logic [CYC_W-1:0]  new_cost;

  assign cond_code      = opcode_i[COND_LSB +: COND_W];
  assign cnt_idx        = opcode_i[IDX_W-1:0];
  assign unused_op_bits = ^{opcode_i[OP_W-1:COND_LSB+COND_W], opcode_i[COND_LSB-1:IDX_W]};

  dbloop_cond u_cond (
    .code_i (cond_code),
    .ccr_i  (ccr_t'(ccr_i)),
    .hit_o  (cond_hit)
  );

  dbloop_regfile #(
    .DEPTH  (NREG),
    .DATA_W (DATA_W)
  ) u_rf (
    .clk      (clk),
    .rst      (rst),
    .rd_idx_i (cnt_idx),
    .rd_val_o (rd_val),
    .sw_en_i  (step_i && new_we),
    .sw_idx_i (cnt_idx),
    .sw_val_i (new_val),
    .ld_en_i  (ld_en_i),
    .ld_idx_i (ld_idx_i),
    .ld_val_i (ld_val_i)
  );

  dbloop_step #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_step (
    .hit_i     (cond_hit),
    .cur_i     (rd_val),
    .pc_i      (pc_i),
    .disp_i    (disp_i),
    .new_o     (new_val),
    .we_o      (new_we),
    .next_pc_o (new_pc),
    .path_o    (path)
  );

  always_comb begin
    unique case (path)
      PATH_HIT:  new_cost = CYC_W'(COST_HIT);
      PATH_WRAP: new_cost = CYC_W'(COST_WRAP);
      default:   new_cost = CYC_W'(COST_LOOP);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      cnt_o     <= '0;
      cnt_we_o  <= 1'b0;
      next_pc_o <= '0;
      cycles_o  <= '0;
    end else begin
      done_o <= step_i;
      if (step_i) begin
        cnt_o     <= new_val;
        cnt_we_o  <= new_we;
        next_pc_o <= new_pc;
        cycles_o  <= new_cost;
      end
    end
  end

  // R8: completion follows each request and only a request
  a_r8_done_after_step: assert property (@(posedge clk) disable iff (rst)
    step_i |=> done_o);
  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> !done_o);
  a_r8_hold_results: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> ($stable(next_pc_o) && $stable(cnt_o) && $stable(cycles_o)));

  // R1: condition met means fall through with no counter write
  a_r1_hit_exit: assert property (@(posedge clk) disable iff (rst)
    (done_o && !cnt_we_o) |-> (next_pc_o == $past(pc_i) + ADDR_W'(2) &&
                                cycles_o == CYC_W'(COST_HIT) && cnt_o == $past(rd_val)));

  // R2: decrement touches only the count field
  a_r2_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (done_o && cnt_we_o) |-> (cnt_o[DATA_W-1:CNT_W] == $past(rd_val[DATA_W-1:CNT_W]) &&
                               cnt_o[CNT_W-1:0] == CNT_W'($past(rd_val[CNT_W-1:0]) - CNT_W'(1))));

  // R3: count wrapped to all ones leaves the loop
  a_r3_wrap_exit: assert property (@(posedge clk) disable iff (rst)
    (done_o && cnt_we_o && (&cnt_o[CNT_W-1:0])) |->
      (cycles_o == CYC_W'(COST_WRAP) && next_pc_o == $past(pc_i) + ADDR_W'(2)));

  // R4: otherwise branch back by the signed displacement
  a_r4_loop_back: assert property (@(posedge clk) disable iff (rst)
    (done_o && cnt_we_o && !(&cnt_o[CNT_W-1:0])) |->
      (cycles_o == CYC_W'(COST_LOOP) &&
       next_pc_o == $past(pc_i) + {{(ADDR_W-DISP_W){$past(disp_i[DISP_W-1])}}, $past(disp_i)}));

  // R6: the never-true code always counts
  a_r6_never_counts: assert property (@(posedge clk) disable iff (rst)
    (step_i && cond_code == COND_W'(1)) |=> cnt_we_o);

endmodule

// File: tb/tb_dbloop_unit.sv
module tb_dbloop_unit;

  typedef struct {
    logic [31:0] cnt;
    logic        we;
    logic [31:0] pc;
    int          cyc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [3:0]  ccr_i = '0;
  logic [31:0] pc_i = '0;
  logic [15:0] disp_i = '0;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_idx_i = '0;
  logic [31:0] ld_val_i = '0;
  logic        done_o;
  logic [31:0] cnt_o;
  logic        cnt_we_o;
  logic [31:0] next_pc_o;
  logic [4:0]  cycles_o;

  int   n_checks = 0;
  int   n_fail = 0;
  logic [31:0] model [8];
  exp_t pend [$];

  always #4 clk = ~clk;

  dbloop_unit dut (
    .clk(clk), .rst(rst), .step_i(step_i), .opcode_i(opcode_i), .ccr_i(ccr_i),
    .pc_i(pc_i), .disp_i(disp_i), .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i),
    .ld_val_i(ld_val_i), .done_o(done_o), .cnt_o(cnt_o), .cnt_we_o(cnt_we_o),
    .next_pc_o(next_pc_o), .cycles_o(cycles_o)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit holds(logic [3:0] code, logic [3:0] f);
    bit n = f[3], z = f[2], v = f[1], c = f[0];
    case (code)
      4'd0: return 1;
      4'd1: return 0;
      4'd2: return !(c || z);
      4'd3: return c || z;
      4'd4: return !c;
      4'd5: return c;
      4'd6: return !z;
      4'd7: return z;
      4'd8: return !v;
      4'd9: return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return (n && v) || (!n && !v);
      4'd13: return (n && !v) || (!n && v);
      4'd14: return ((n && v) || (!n && !v)) && !z;
      default: return z || (n && !v) || (!n && v);
    endcase
  endfunction

  function automatic logic [15:0] mkop(logic [3:0] code, logic [2:0] idx, bit junk);
    return junk ? {4'hA, code, 5'b00110, idx} : {4'h5, code, 5'b11001, idx};
  endfunction

  // advance one clock and compare everything visible against the model
  task automatic tick();
    @(negedge clk);
    if (pend.size() > 0) begin
      exp_t e = pend.pop_front();
      chk(e.tag, "done", 64'(done_o), 64'd1);
      chk(e.tag, "cnt", 64'(cnt_o), 64'(e.cnt));
      chk(e.tag, "we", 64'(cnt_we_o), 64'(e.we));
      chk(e.tag, "next_pc", 64'(next_pc_o), 64'(e.pc));
      chk(e.tag, "cycles", 64'(cycles_o), 64'(e.cyc));
    end else begin
      chk("R8", "idle done", 64'(done_o), 64'd0);
    end
  endtask

  task automatic step(logic [15:0] op, logic [3:0] f, logic [31:0] pc,
                      logic [15:0] disp, string tag);
    exp_t e;
    logic [2:0]  idx = op[2:0];
    logic [31:0] old = model[idx];
    logic [15:0] lo;
    opcode_i = op; ccr_i = f; pc_i = pc; disp_i = disp; step_i = 1'b1;
    e.tag = tag;
    if (ld_en_i) model[ld_idx_i] = ld_val_i;
    if (holds(op[11:8], f)) begin
      e.cnt = old; e.we = 1'b0; e.pc = pc + 32'd2; e.cyc = 12;
    end else begin
      lo = old[15:0] - 16'd1;
      e.cnt = {old[31:16], lo}; e.we = 1'b1;
      model[idx] = e.cnt;
      if (lo == 16'hFFFF) begin
        e.pc = pc + 32'd2; e.cyc = 14;
      end else begin
        e.pc = pc + {{16{disp[15]}}, disp}; e.cyc = 10;
      end
    end
    pend.push_back(e);
    tick();
    step_i = 1'b0;
    ld_en_i = 1'b0;
  endtask

  task automatic load(logic [2:0] idx, logic [31:0] val);
    ld_en_i = 1'b1; ld_idx_i = idx; ld_val_i = val;
    model[idx] = val;
    tick();
    ld_en_i = 1'b0;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7", "reset done", 64'(done_o), 64'd0);
    chk("R7", "reset cnt", 64'(cnt_o), 64'd0);
    chk("R7", "reset pc", 64'(next_pc_o), 64'd0);
    chk("R7", "reset cycles", 64'(cycles_o), 64'd0);

    // R7 + R3: cleared counter wraps on first decrement
    step(mkop(4'd1, 3'd3, 0), 4'h0, 32'h0000_2000, 16'hFFF0, "R7");
    tick();

    // R4, R2, R3: walk a short loop with a marked upper half, back-to-back
    load(3'd2, 32'hABCD_0003);
    step(mkop(4'd1, 3'd2, 0), 4'hF, 32'h0000_1000, 16'hFFFC, "R4");
    step(mkop(4'd1, 3'd2, 0), 4'h0, 32'h0000_1000, 16'hFFFC, "R2");
    step(mkop(4'd1, 3'd2, 0), 4'h5, 32'h0000_1000, 16'hFFFC, "R2");
    step(mkop(4'd1, 3'd2, 0), 4'hA, 32'h0000_1000, 16'hFFFC, "R3");
    step(mkop(4'd1, 3'd2, 0), 4'h3, 32'h0000_1000, 16'hFFFC, "R4");
    tick();

    // R4: positive displacement
    load(3'd4, 32'h0000_0100);
    step(mkop(4'd7, 3'd4, 0), 4'h0, 32'h0000_3000, 16'h0040, "R4");

    // R1: condition met, counter unchanged
    step(mkop(4'd0, 3'd4, 0), 4'h0, 32'h0000_3002, 16'h1234, "R1");
    step(mkop(4'd7, 3'd4, 0), 4'h4, 32'hFFFF_FFFE, 16'h8000, "R1");

    // R5: every code against every flag combination
    load(3'd5, 32'h5A5A_0200);
    for (int code = 0; code < 16; code++)
      for (int f = 0; f < 16; f++)
        step(mkop(4'(code), 3'd5, 0), 4'(f), 32'h0000_4000 + 32'(f * 4),
             16'hFFF8, "R5");

    // R6: never-true code counts regardless of flags
    load(3'd6, 32'h0000_0002);
    for (int f = 0; f < 16; f++)
      step(mkop(4'd1, 3'd6, 0), 4'(f), 32'h0000_5000, 16'hFFF0, "R6");

    // R10: unrelated opcode bits have no effect
    load(3'd1, 32'h1111_0005);
    step(mkop(4'd6, 3'd1, 1), 4'h0, 32'h0000_6000, 16'hFFEE, "R10");
    step(mkop(4'd6, 3'd1, 1), 4'h4, 32'h0000_6000, 16'hFFEE, "R10");
    step(mkop(4'd1, 3'd1, 1), 4'h4, 32'h0000_6000, 16'hFFEE, "R10");

    // R9: same-counter load loses to a writing step
    ld_en_i = 1'b1; ld_idx_i = 3'd0; ld_val_i = 32'hDEAD_0000;
    step(mkop(4'd1, 3'd0, 0), 4'h0, 32'h0000_7000, 16'h0010, "R9");
    step(mkop(4'd0, 3'd0, 0), 4'h0, 32'h0000_7000, 16'h0010, "R9");
    // R9: load during a step whose condition holds lands
    ld_en_i = 1'b1; ld_idx_i = 3'd0; ld_val_i = 32'hBEEF_0009;
    step(mkop(4'd0, 3'd0, 0), 4'h0, 32'h0000_7000, 16'h0010, "R9");
    step(mkop(4'd0, 3'd0, 0), 4'h0, 32'h0000_7000, 16'h0010, "R9");
    // R9: load to another counter alongside a writing step
    ld_en_i = 1'b1; ld_idx_i = 3'd7; ld_val_i = 32'h7777_0001;
    step(mkop(4'd1, 3'd0, 0), 4'h0, 32'h0000_7100, 16'h0010, "R9");
    step(mkop(4'd1, 3'd7, 0), 4'h0, 32'h0000_7200, 16'h0010, "R9");
    tick();
    tick();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule